// File: doc/BRIEF.md
# Cascadable Display Column Data Latch

This block is the digital front end of a display column driver. Once a start pulse arms it, it takes one pixel per clock. A pixel is three 6-bit colour words (red, green and blue), and each pixel is written into the next group of three adjacent column latches. When the last pixel slot of the line has been written, the block sends a one-clock carry pulse out on the start pin at the far end of the fill direction. Several devices can therefore be chained, with each carry output wired to the start input of the next device, to build a wider line.

A load strobe is sampled on the clock. On its rising edge the block copies the whole line of column latches into a bank of output hold registers and samples a polarity bit. The strobe may arrive at any time, including partway through a line. The fill direction can be set upward (from channel 1) or downward (from the top channel). Each captured word can be stored as its bitwise complement. A reduced mode removes a group of nine middle channels, which makes the line three pixels shorter. The hold registers and the latched polarity form the output; analog conversion happens outside this block.

Top module: `col_latch`

## Requirements
- R1: After reset every hold channel reads 0, the latched polarity reads 0, both carry outputs are low and no capture is armed.
- R2: Each clock edge after the arming edge captures one pixel into pixel slot p. The red word goes to channel 3p+1, green to 3p+2 and blue to 3p+3 (channels numbered from 1). Channel c appears on bits [(c-1)*6 +: 6] of `hold_out`, with bit 5 of each word as its MSB.
- R3: When `invert` is 1 at a capture edge, each of the three words is stored as its bitwise complement (for example 00 is stored as 3F, and 15 as 2A).
- R4: With `dir_up` = 1, a rising level on `start_a_in` arms capture. Filling runs through slots 0, 1, 2 and so on upward, and the end-of-line carry appears on `carry_b_out`.
- R5: With `dir_up` = 0, a rising level on `start_b_in` arms capture. Filling runs from the top slot downward to slot 0, and the carry appears on `carry_a_out`.
- R6: The carry output goes high for exactly one clock, set by the edge that captures the last pixel. In full mode (309 channels) that edge is the 103rd capture edge after the arming edge. No further capture takes place until the next arming.
- R7: With `reduced` = 1, pixel slots 50 to 52 (channels 151 to 159) are skipped, so a line takes 100 capture edges, and those channels read 0 at `hold_out`.
- R8: A start pulse held high for several clocks arms only once, on its first sampled high level. A new rising level that arrives during a line restarts the line at its first slot, and that edge captures nothing.
- R9: On the clock edge where `load` is first sampled high, the hold registers take the line latches as they stood before that edge, and `pol_out` takes `pol`. While `load` stays high, or stays low, the hold registers and `pol_out` do not change.
- R10: A load taken during a partially filled line transfers the slots written so far. Slots not yet written keep their contents from earlier lines.
- R11: A start pulse on the input pin that belongs to the other direction does not arm capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| red | input | 6 | Red word of the current pixel |
| green | input | 6 | Green word of the current pixel |
| blue | input | 6 | Blue word of the current pixel |
| invert | input | 1 | Store the complement of each captured word |
| reduced | input | 1 | Select the 300-channel mode that skips the middle group |
| dir_up | input | 1 | 1: fill upward from channel 1; 0: fill downward |
| start_a_in | input | 1 | Start input at the low end of the line (used when dir_up = 1) |
| start_b_in | input | 1 | Start input at the high end of the line (used when dir_up = 0) |
| carry_a_out | output | 1 | Carry pulse at the low end (downward fill) |
| carry_b_out | output | 1 | Carry pulse at the high end (upward fill) |
| load | input | 1 | Load strobe; its rising level transfers the line and samples pol |
| pol | input | 1 | Polarity bit sampled by the load strobe |
| hold_out | output | 1854 | Hold registers, 309 channels of 6 bits each |
| pol_out | output | 1 | Latched polarity |

## Verification
The assertions assume that `dir_up` and `reduced` change only while no line is being filled, because a mode change partway through a line would move the fill pointer onto slots the checks treat as out of order. The hold-stability check also allows for `reduced` changing, since that input masks the middle channels directly. The stimulus sets both mode inputs only between lines, while the carry pulse of the previous line is low and before the next start pulse. Pixel data, `invert`, `pol`, `load` and the start pins are driven a few nanoseconds after each falling clock edge, so that every sampled value is stable at the rising edge.

// File: rtl/col_latch.sv
module col_latch #(
  parameter int CH         = 309,
  parameter int W          = 6,
  parameter int SKIP_SLOT  = 50,
  parameter int SKIP_SLOTS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    red,
  input  logic [W-1:0]    green,
  input  logic [W-1:0]    blue,
  input  logic            invert,
  input  logic            reduced,
  input  logic            dir_up,
  input  logic            start_a_in,
  input  logic            start_b_in,
  output logic            carry_a_out,
  output logic            carry_b_out,
  input  logic            load,
  input  logic            pol,
  output logic [CH*W-1:0] hold_out,
  output logic            pol_out
);
  localparam int SLOTS = CH / 3;
  localparam int IW    = $clog2(SLOTS);
  localparam int CW    = $clog2(CH);
  localparam logic [IW-1:0] TOP     = IW'(SLOTS - 1);
  localparam logic [IW-1:0] SKIP_LO = IW'(SKIP_SLOT);
  localparam logic [IW-1:0] SKIP_HI = IW'(SKIP_SLOT + SKIP_SLOTS - 1);

  logic [W-1:0] line [CH];
  logic [W-1:0] hold [CH];
  logic          start_q, active, load_q;
  logic [IW-1:0] idx, nxt;
  logic [CW-1:0] base;

  wire start_in = dir_up ? start_a_in : start_b_in;
  wire arm      = start_in & ~start_q;
  wire at_last  = dir_up ? (idx == TOP) : (idx == '0);
  wire [W-1:0] mask = {W{invert}};

  assign base = CW'(idx) * CW'(3);

  always_comb begin
    if (dir_up) nxt = (reduced && idx + 1'b1 == SKIP_LO) ? SKIP_HI + 1'b1 : idx + 1'b1;
    else        nxt = (reduced && idx - 1'b1 == SKIP_HI) ? SKIP_LO - 1'b1 : idx - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      load_q      <= 1'b0;
      active      <= 1'b0;
      idx         <= '0;
      carry_a_out <= 1'b0;
      carry_b_out <= 1'b0;
      pol_out     <= 1'b0;
      for (int c = 0; c < CH; c++) begin
        line[c] <= '0;
        hold[c] <= '0;
      end
    end else begin
      start_q     <= start_in;
      load_q      <= load;
      carry_a_out <= 1'b0;
      carry_b_out <= 1'b0;
      if (load && !load_q) begin
        hold    <= line;
        pol_out <= pol;
      end
      if (arm) begin
        active <= 1'b1;
        idx    <= dir_up ? '0 : TOP;
      end else if (active) begin
        line[base]          <= red   ^ mask;
        line[base + CW'(1)] <= green ^ mask;
        line[base + CW'(2)] <= blue  ^ mask;
        if (at_last) begin
          active      <= 1'b0;
          carry_b_out <= dir_up;
          carry_a_out <= ~dir_up;
        end else begin
          idx <= nxt;
        end
      end
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_out
    localparam bit SKIPPED = (c / 3 >= SKIP_SLOT) && (c / 3 < SKIP_SLOT + SKIP_SLOTS);
    if (SKIPPED) begin : g_skip
      assign hold_out[c*W +: W] = reduced ? '0 : hold[c];
    end else begin : g_keep
      assign hold_out[c*W +: W] = hold[c];
    end
  end
endmodule

// File: rtl/col_latch_chk.sv
module col_latch_chk #(
  parameter int HW = 1854
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_up,
  input logic          reduced,
  input logic          load,
  input logic          load_q,
  input logic          start_in,
  input logic          start_q,
  input logic          active,
  input logic          carry_a_out,
  input logic          carry_b_out,
  input logic [HW-1:0] hold_out,
  input logic          pol_out
);
  p_carry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_a_out || carry_b_out) |=> !(carry_a_out || carry_b_out));

  p_carry_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_b_out |-> (!carry_a_out && $past(dir_up)));

  p_carry_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry_a_out |-> $past(!dir_up));

  p_arm_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_in && !start_q) |=> active);

  p_idle_after_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_a_out || carry_b_out) |-> !active);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && !load_q) |=> ($stable(pol_out) && (!$stable(reduced) || $stable(hold_out))));
endmodule

bind col_latch col_latch_chk #(.HW(CH*W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .reduced(reduced),
  .load(load), .load_q(load_q), .start_in(start_in), .start_q(start_q),
  .active(active), .carry_a_out(carry_a_out), .carry_b_out(carry_b_out),
  .hold_out(hold_out), .pol_out(pol_out)
);

// File: tb/col_latch_test.sv
module col_latch_test;
  localparam int CH = 309;
  localparam int NS = CH / 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] red = '0, green = '0, blue = '0;
  logic invert = 0, reduced = 0, dir_up = 1, start_a_in = 0, start_b_in = 0;
  logic load = 0, pol = 0;
  logic carry_a_out, carry_b_out, pol_out;
  logic [CH*6-1:0] hold_out;

  always #10 clk = ~clk;

  col_latch uut (.*);

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int m_line[CH], m_hold[CH], m_pol;
  int order[$];
  bit m_act, m_sq, m_lq, m_ca, m_cb;

  function automatic bit skipped(int slot);
    return reduced && slot >= 50 && slot <= 52;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_line[c]) begin m_line[c] = 0; m_hold[c] = 0; end
      m_pol = 0; m_act = 0; m_sq = 0; m_lq = 0; m_ca = 0; m_cb = 0;
      order.delete();
    end else begin
      bit sel;
      sel = dir_up ? start_a_in : start_b_in;
      m_ca = 0; m_cb = 0;
      if (load && !m_lq) begin
        foreach (m_line[c]) m_hold[c] = m_line[c];
        m_pol = pol;
      end
      m_lq = load;
      if (sel && !m_sq) begin
        order.delete();
        for (int k = 0; k < NS; k++) begin
          int s;
          s = dir_up ? k : NS - 1 - k;
          if (!skipped(s)) order.push_back(s);
        end
        m_act = 1;
      end else if (m_act) begin
        int s, x;
        s = order.pop_front();
        x = invert ? 63 : 0;
        m_line[3*s]   = red ^ x;
        m_line[3*s+1] = green ^ x;
        m_line[3*s+2] = blue ^ x;
        if (order.size() == 0) begin
          m_act = 0;
          if (dir_up) m_cb = 1; else m_ca = 1;
        end
      end
      m_sq = sel;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int bad, got, exp;
      bad = -1;
      for (int c = 0; c < CH; c++) begin
        exp = skipped(c / 3) ? 0 : m_hold[c];
        got = hold_out[c*6 +: 6];
        if (bad < 0 && got != exp) bad = c;
      end
      checks++;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s: channel %0d actual %h expected %h", cur_req, bad + 1,
                 hold_out[bad*6 +: 6], skipped(bad / 3) ? 0 : m_hold[bad]);
      end else if (carry_a_out !== m_ca || carry_b_out !== m_cb || pol_out !== m_pol[0]) begin
        fails++;
        $display("FAIL %s: carry_a/carry_b/pol actual %b%b%b expected %b%b%b", cur_req,
                 carry_a_out, carry_b_out, pol_out, m_ca, m_cb, m_pol[0]);
      end
    end
  end

  bit rnd_en = 0;
  always @(negedge clk) begin
    #1;
    if (rnd_en) begin
      red = 6'($urandom_range(0, 63));
      green = 6'($urandom_range(0, 63));
      blue = 6'($urandom_range(0, 63));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse start for `width` cycles, return edges until carry is seen
  task automatic run_line(bit up, int width, output int edges);
    bit seen;
    dir_up = up;
    tick();
    if (up) start_a_in = 1; else start_b_in = 1;
    edges = 0; seen = 0;
    while (!seen && edges < 400) begin
      tick();
      edges++;
      if (edges == width) begin start_a_in = 0; start_b_in = 0; end
      seen = up ? carry_b_out : carry_a_out;
    end
    start_a_in = 0; start_b_in = 0;
  endtask

  task automatic do_load(bit p, int hold_cycles);
    pol = p; load = 1; tick(hold_cycles); load = 0; tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int e;
    tick(3);
    check("R1", {31'b0, carry_a_out | carry_b_out | pol_out}, 0);
    check("R1", {31'b0, |hold_out}, 0);
    rst_n = 1; tick(2);
    rnd_en = 1;

    cur_req = "R2/R4/R6";
    run_line(1, 1, e);
    check("R6", e, 104);
    tick();
    check("R6", {31'b0, carry_b_out}, 0);
    cur_req = "R9"; do_load(1, 1);

    cur_req = "R3/R5"; invert = 1;
    run_line(0, 1, e);
    check("R5", e, 104);
    invert = 0;
    cur_req = "R9"; do_load(0, 6);

    cur_req = "R7"; reduced = 1;
    run_line(1, 1, e);
    check("R7", e, 101);
    do_load(1, 1);
    reduced = 0; tick(2);
    reduced = 1; tick(2); reduced = 0;

    cur_req = "R8";
    run_line(1, 5, e);
    check("R8", e, 104);
    tick(3);
    check("R8", {31'b0, carry_b_out}, 0);
    dir_up = 1; start_a_in = 1; tick(20);
    start_a_in = 0; tick(10);
    start_a_in = 1; tick();
    start_a_in = 0; tick(110);
    do_load(0, 1);

    cur_req = "R11";
    dir_up = 1; start_b_in = 1; tick(3); start_b_in = 0; tick(120);
    check("R11", {31'b0, carry_a_out | carry_b_out}, 0);
    do_load(1, 1);
    dir_up = 0; start_a_in = 1; tick(3); start_a_in = 0; tick(120);
    do_load(0, 1);

    cur_req = "R10";
    dir_up = 1; start_a_in = 1; tick(); start_a_in = 0;
    tick(12);
    do_load(1, 4);
    tick(95);
    do_load(0, 1);

    rnd_en = 0; tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule